// File: doc/BRIEF.md
# Dual-Candidate SAD Block Matcher

This block runs a full-search block-matching step for motion estimation. A reference block of BLK×BLK 8-bit pixels from the current frame is first loaded column by column. It then serves as the mask for the search.

The search area comes from the previous frame. It is (BLK+2·RANGE) pixels square. It is streamed in as columns that are BLK+1 pixels tall, and each column is broadcast to two absolute-difference units. The upper unit uses rows 0..BLK-1 of the column and the lower unit uses rows 1..BLK. Two vertically adjacent candidate positions are therefore scored from one read of their shared rows.

The engine keeps the smallest sum of absolute differences (SAD) and its displacement. It reports that displacement as a signed motion vector and pulses `done_o` when every one of the (2·RANGE+1)² positions has been scored. A new reference block can then be loaded for the next macroblock.

The upstream feeder must send beats in a fixed order. There are three nested loops:
- Outermost, for horizontal index dxi = 0..2·RANGE.
- Then for pair index k = 0..RANGE.
- Innermost, for j = 0..BLK-1, one beat that carries search-area column dxi+j, rows 2k..2k+BLK.

The upper candidate of pair k has dy = 2k-RANGE and the lower candidate has dy = 2k-RANGE+1. In all cases dx = dxi-RANGE.

Top module: `dual_sad_matcher`

## Requirements
- R1: After reset, `busy_o` and `done_o` are 0, `mv_x_o` and `mv_y_o` are 0, and `sad_o` is all ones.
- R2: While idle, each cycle with `ref_valid_i` high stores one reference column, in column order 0..BLK-1. Pixel row r sits in bits [8r+7:8r]. `busy_o` rises in the cycle after the BLK-th column is accepted.
- R3: While `busy_o` is high, `ref_valid_i` is ignored and the mask in use is left unchanged.
- R4: While `busy_o` is low, `srch_valid_i` is ignored. It counts no beat and changes no output.
- R5: A candidate's SAD is the sum, over BLK×BLK pixels, of |ref − search|. Each beat carries search pixel row i in bits [8i+7:8i]. The upper unit pairs beat row r with reference row r, and the lower unit pairs beat row r+1 with reference row r. Within a pass, beat j pairs with reference column j.
- R6: In the last pass (k = RANGE), the lower candidate would fall outside the search range. It is never scored, and row BLK of those beats has no effect.
- R7: At `done_o`, `sad_o` is the minimum SAD over all positions. `mv_x_o` and `mv_y_o` are its signed dx and dy, each within ±RANGE.
- R8: On equal SAD, the position visited first wins. The order is dx ascending, then dy ascending.
- R9: `done_o` is a one-cycle pulse in the cycle after the last of (2·RANGE+1)·(RANGE+1)·BLK search beats. `busy_o` falls in that same cycle.
- R10: When `busy_o` rises, the best SAD restarts from all ones, so a search reports its own minimum even if an earlier search found a smaller one.
- R11: Cycles with `srch_valid_i` low inside a search are idle gaps that do not advance the scan.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ref_valid_i | input | 1 | Reference column strobe |
| ref_col_i | input | BLK*8 | Reference column, row r in bits [8r+7:8r] |
| srch_valid_i | input | 1 | Search column strobe |
| srch_col_i | input | (BLK+1)*8 | Search column, BLK+1 rows |
| busy_o | output | 1 | Search in progress |
| done_o | output | 1 | One-cycle end-of-search pulse |
| mv_x_o | output | clog2(RANGE+1)+1 | Signed horizontal motion vector |
| mv_y_o | output | clog2(RANGE+1)+1 | Signed vertical motion vector |
| sad_o | output | 8+2*clog2(BLK) | Best SAD |

## Verification
Several searches are run, each aimed at one corner case:
- One search has a flat image, so every position ties at zero. A design that let later equal scores win would report the last position instead of (−RANGE, −RANGE).
- One search puts a perfect match in the out-of-range row of the last pass. A design that scored that lower candidate would report dy = RANGE+1 with a zero SAD.
- One search yields only large SADs and follows a zero-SAD search. A design that kept the best score across macroblocks would repeat the stale zero result.
- Reference strobes sent during a search, idle gaps, and search beats sent while idle are mixed in. A design that corrupted the mask or counted stray beats would shift the done pulse or the vector.

// File: rtl/sadm_pkg.sv
package sadm_pkg;
  localparam int PIX_W = 8;

  function automatic int sad_width(input int blk);
    return PIX_W + 2 * $clog2(blk);
  endfunction

  function automatic int mv_width(input int range);
    return $clog2(range + 1) + 1;
  endfunction

  function automatic int idx_width(input int n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction
endpackage

// File: rtl/sad_col_unit.sv
module sad_col_unit
  import sadm_pkg::*;
#(
  parameter int BLK   = 4,
  parameter int SUM_W = 12
) (
  input  logic [BLK*PIX_W-1:0] ref_col_i,
  input  logic [BLK*PIX_W-1:0] pix_col_i,
  output logic [SUM_W-1:0]     sum_o
);
  logic [PIX_W-1:0] ad [BLK];

  for (genvar r = 0; r < BLK; r++) begin : g_ad
    logic [PIX_W-1:0] a, b;
    assign a     = ref_col_i[r*PIX_W +: PIX_W];
    assign b     = pix_col_i[r*PIX_W +: PIX_W];
    assign ad[r] = (a > b) ? (a - b) : (b - a);
  end

  always_comb begin
    sum_o = '0;
    for (int r = 0; r < BLK; r++) sum_o = sum_o + SUM_W'(ad[r]);
  end
endmodule

// File: rtl/sad_scan_ctrl.sv
module sad_scan_ctrl
  import sadm_pkg::*;
#(
  parameter int BLK   = 4,
  parameter int RANGE = 2,
  localparam int SPAN  = 2 * RANGE + 1,
  localparam int NPAIR = RANGE + 1,
  localparam int COL_W = idx_width(BLK),
  localparam int DX_W  = idx_width(SPAN),
  localparam int PR_W  = idx_width(NPAIR)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic             beat_i,
  output logic [COL_W-1:0] col_o,
  output logic [DX_W-1:0]  dx_o,
  output logic [PR_W-1:0]  pair_o,
  output logic             col_last_o,
  output logic             lower_ok_o,
  output logic             scan_last_o
);
  logic pair_last, dx_last;

  assign col_last_o  = (col_o == COL_W'(BLK - 1));
  assign pair_last   = (pair_o == PR_W'(NPAIR - 1));
  assign dx_last     = (dx_o == DX_W'(SPAN - 1));
  assign lower_ok_o  = !pair_last;   // last pass: lower candidate out of range
  assign scan_last_o = col_last_o && pair_last && dx_last;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      col_o  <= '0;
      dx_o   <= '0;
      pair_o <= '0;
    end else if (start_i) begin
      col_o  <= '0;
      dx_o   <= '0;
      pair_o <= '0;
    end else if (beat_i) begin
      if (col_last_o) begin
        col_o <= '0;
        if (pair_last) begin
          pair_o <= '0;
          dx_o   <= dx_last ? '0 : dx_o + 1'b1;
        end else begin
          pair_o <= pair_o + 1'b1;
        end
      end else begin
        col_o <= col_o + 1'b1;
      end
    end
  end
endmodule

// File: rtl/sad_best_track.sv
module sad_best_track
  import sadm_pkg::*;
#(
  parameter int SAD_W = 12,
  parameter int MV_W  = 3
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    init_i,
  input  logic                    eval_i,
  input  logic [SAD_W-1:0]        sad_a_i,
  input  logic [SAD_W-1:0]        sad_b_i,
  input  logic                    b_ok_i,
  input  logic signed [MV_W-1:0]  dx_i,
  input  logic signed [MV_W-1:0]  dy_i,
  output logic [SAD_W-1:0]        best_o,
  output logic signed [MV_W-1:0]  mv_x_o,
  output logic signed [MV_W-1:0]  mv_y_o
);
  logic [SAD_W-1:0]       n_sad;
  logic signed [MV_W-1:0] n_x, n_y;

  // upper candidate is earlier in scan order; strict compare keeps first on ties
  always_comb begin
    n_sad = best_o;
    n_x   = mv_x_o;
    n_y   = mv_y_o;
    if (sad_a_i < n_sad) begin
      n_sad = sad_a_i;
      n_x   = dx_i;
      n_y   = dy_i;
    end
    if (b_ok_i && (sad_b_i < n_sad)) begin
      n_sad = sad_b_i;
      n_x   = dx_i;
      n_y   = dy_i + MV_W'(1);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      best_o <= '1;
      mv_x_o <= '0;
      mv_y_o <= '0;
    end else if (init_i) begin
      best_o <= '1;
      mv_x_o <= '0;
      mv_y_o <= '0;
    end else if (eval_i) begin
      best_o <= n_sad;
      mv_x_o <= n_x;
      mv_y_o <= n_y;
    end
  end
endmodule

// File: rtl/dual_sad_matcher.sv
module dual_sad_matcher
  import sadm_pkg::*;
#(
  parameter int BLK   = 4,
  parameter int RANGE = 2
) (
  input  logic                                  clk_i,
  input  logic                                  rst_ni,
  input  logic                                  ref_valid_i,
  input  logic [BLK*PIX_W-1:0]                  ref_col_i,
  input  logic                                  srch_valid_i,
  input  logic [(BLK+1)*PIX_W-1:0]              srch_col_i,
  output logic                                  busy_o,
  output logic                                  done_o,
  output logic signed [mv_width(RANGE)-1:0]     mv_x_o,
  output logic signed [mv_width(RANGE)-1:0]     mv_y_o,
  output logic [sad_width(BLK)-1:0]             sad_o
);
  localparam int SAD_W = sad_width(BLK);
  localparam int MV_W  = mv_width(RANGE);
  localparam int SPAN  = 2 * RANGE + 1;
  localparam int NPAIR = RANGE + 1;
  localparam int COL_W = idx_width(BLK);
  localparam int DX_W  = idx_width(SPAN);
  localparam int PR_W  = idx_width(NPAIR);

  logic [BLK*PIX_W-1:0] ref_q [BLK];
  logic [COL_W-1:0]     ld_cnt;
  logic [SAD_W-1:0]     acc_a, acc_b, sum_a, sum_b, tot_a, tot_b;
  logic [COL_W-1:0]     col;
  logic [DX_W-1:0]      dx_idx;
  logic [PR_W-1:0]      pair_idx;
  logic                 col_last, lower_ok, scan_last;
  logic signed [MV_W-1:0] dx_s, dy_s;

  logic ref_take, load_done, beat, eval;

  assign ref_take  = ref_valid_i && !busy_o;
  assign load_done = ref_take && (ld_cnt == COL_W'(BLK - 1));
  assign beat      = srch_valid_i && busy_o;
  assign eval      = beat && col_last;

  // reference mask storage
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int c = 0; c < BLK; c++) ref_q[c] <= '0;
      ld_cnt <= '0;
    end else if (ref_take) begin
      ref_q[ld_cnt] <= ref_col_i;
      ld_cnt        <= load_done ? '0 : ld_cnt + 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_o <= 1'b0;
      done_o <= 1'b0;
    end else begin
      done_o <= beat && scan_last;
      if (load_done)              busy_o <= 1'b1;
      else if (beat && scan_last) busy_o <= 1'b0;
    end
  end

  sad_scan_ctrl #(.BLK(BLK), .RANGE(RANGE)) u_scan (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .start_i     (load_done),
    .beat_i      (beat),
    .col_o       (col),
    .dx_o        (dx_idx),
    .pair_o      (pair_idx),
    .col_last_o  (col_last),
    .lower_ok_o  (lower_ok),
    .scan_last_o (scan_last)
  );

  // both units see the same broadcast column, offset by one row
  sad_col_unit #(.BLK(BLK), .SUM_W(SAD_W)) u_upper (
    .ref_col_i (ref_q[col]),
    .pix_col_i (srch_col_i[0 +: BLK*PIX_W]),
    .sum_o     (sum_a)
  );

  sad_col_unit #(.BLK(BLK), .SUM_W(SAD_W)) u_lower (
    .ref_col_i (ref_q[col]),
    .pix_col_i (srch_col_i[PIX_W +: BLK*PIX_W]),
    .sum_o     (sum_b)
  );

  assign tot_a = acc_a + sum_a;
  assign tot_b = acc_b + sum_b;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      acc_a <= '0;
      acc_b <= '0;
    end else if (load_done) begin
      acc_a <= '0;
      acc_b <= '0;
    end else if (beat) begin
      acc_a <= col_last ? '0 : tot_a;
      acc_b <= col_last ? '0 : tot_b;
    end
  end

  assign dx_s = MV_W'(int'(dx_idx) - RANGE);
  assign dy_s = MV_W'(2 * int'(pair_idx) - RANGE);

  sad_best_track #(.SAD_W(SAD_W), .MV_W(MV_W)) u_best (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .init_i  (load_done),
    .eval_i  (eval),
    .sad_a_i (tot_a),
    .sad_b_i (tot_b),
    .b_ok_i  (lower_ok),
    .dx_i    (dx_s),
    .dy_i    (dy_s),
    .best_o  (sad_o),
    .mv_x_o  (mv_x_o),
    .mv_y_o  (mv_y_o)
  );
endmodule

// File: rtl/dual_sad_matcher_chk.sv
module dual_sad_matcher_chk
  import sadm_pkg::*;
#(
  parameter int BLK   = 4,
  parameter int RANGE = 2,
  localparam int SAD_W = sad_width(BLK),
  localparam int MV_W  = mv_width(RANGE)
) (
  input logic                   clk_i,
  input logic                   rst_ni,
  input logic                   busy_i,
  input logic                   done_i,
  input logic signed [MV_W-1:0] mv_x_i,
  input logic signed [MV_W-1:0] mv_y_i,
  input logic [SAD_W-1:0]       sad_i
);
  // R9
  done_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_i |=> !done_i);

  // R9
  done_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_i |-> !busy_i && $past(busy_i));

  // R7
  sad_monotone_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_i && $past(busy_i)) |-> (sad_i <= $past(sad_i)));

  // R10
  sad_init_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_i) |-> (sad_i == {SAD_W{1'b1}}));

  // R7
  mv_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_i |-> (mv_x_i >= -RANGE && mv_x_i <= RANGE &&
                mv_y_i >= -RANGE && mv_y_i <= RANGE));

  // R4
  idle_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_i && $past(!busy_i) && !$rose(busy_i)) |-> $stable(sad_i));
endmodule

bind dual_sad_matcher dual_sad_matcher_chk #(.BLK(BLK), .RANGE(RANGE)) u_chk (
  .clk_i  (clk_i),
  .rst_ni (rst_ni),
  .busy_i (busy_o),
  .done_i (done_o),
  .mv_x_i (mv_x_o),
  .mv_y_i (mv_y_o),
  .sad_i  (sad_o)
);

// File: tb/dual_sad_matcher_bench.sv
module dual_sad_matcher_bench;
  import sadm_pkg::*;
  localparam int N     = 4;
  localparam int P     = 2;
  localparam int H     = N + 2 * P;
  localparam int SAD_W = sad_width(N);
  localparam int MV_W  = mv_width(P);
  localparam int TOTAL = (2 * P + 1) * (P + 1) * N;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ref_valid = 1'b0;
  logic [N*8-1:0] ref_col = '0;
  logic srch_valid = 1'b0;
  logic [(N+1)*8-1:0] srch_col = '0;
  logic busy, done;
  logic signed [MV_W-1:0] mv_x, mv_y;
  logic [SAD_W-1:0] sad;

  always #10 clk = ~clk;

  dual_sad_matcher #(.BLK(N), .RANGE(P)) u_dual_sad_matcher (
    .clk_i(clk), .rst_ni(rst_n), .ref_valid_i(ref_valid), .ref_col_i(ref_col),
    .srch_valid_i(srch_valid), .srch_col_i(srch_col), .busy_o(busy),
    .done_o(done), .mv_x_o(mv_x), .mv_y_o(mv_y), .sad_o(sad)
  );

  int n_chk = 0, n_fail = 0;
  int area [H][H];
  int refb [N][N];
  int trap [H];
  // model state
  int m_ref [N][N];
  int m_busy = 0, m_done = 0, m_ld = 0, m_beat = 0;
  int e_sad = (1 << SAD_W) - 1, e_x = 0, e_y = 0;
  string res_req = "R7";

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic void model_search();
    e_sad = (1 << SAD_W) - 1;
    for (int dxi = 0; dxi <= 2 * P; dxi++)
      for (int dyi = 0; dyi <= 2 * P; dyi++) begin
        int s = 0;
        for (int r = 0; r < N; r++)
          for (int c = 0; c < N; c++) begin
            int d = m_ref[r][c] - area[dyi + r][dxi + c];
            s += (d < 0) ? -d : d;
          end
        if (s < e_sad) begin e_sad = s; e_x = dxi - P; e_y = dyi - P; end
      end
  endfunction

  // one clock: drive at negedge, model at posedge, check at next negedge
  task automatic tick(input bit rv, input logic [N*8-1:0] rc,
                      input bit sv, input logic [(N+1)*8-1:0] sc);
    ref_valid = rv; ref_col = rc; srch_valid = sv; srch_col = sc;
    @(posedge clk);
    m_done = 0;
    if (m_busy == 0) begin
      if (rv) begin
        for (int r = 0; r < N; r++) m_ref[r][m_ld] = int'(rc[r*8 +: 8]);
        m_ld++;
        if (m_ld == N) begin
          m_ld = 0; m_busy = 1; m_beat = 0;
          e_sad = (1 << SAD_W) - 1; e_x = 0; e_y = 0;
        end
      end
    end else if (sv) begin
      m_beat++;
      if (m_beat == TOTAL) begin m_busy = 0; m_done = 1; model_search(); end
    end
    @(negedge clk);
    check(busy == m_busy[0], "R2/R9", "busy_o", int'(busy), m_busy);
    check(done == m_done[0], "R9", "done_o", int'(done), m_done);
    if (m_done != 0 || m_busy == 0) begin
      check(int'(sad) == e_sad, res_req, "sad_o", int'(sad), e_sad);
      check(int'(mv_x) == e_x, res_req, "mv_x_o", int'(mv_x), e_x);
      check(int'(mv_y) == e_y, res_req, "mv_y_o", int'(mv_y), e_y);
    end
  endtask

  task automatic load_ref();
    for (int c = 0; c < N; c++) begin
      logic [N*8-1:0] col;
      for (int r = 0; r < N; r++) col[r*8 +: 8] = 8'(refb[r][c]);
      tick(1'b1, col, 1'b0, '0);
    end
  endtask

  // gaps: insert idle cycles; junk: reference strobes during the search (R3)
  task automatic run_search(input bit gaps, input bit junk);
    for (int dxi = 0; dxi <= 2 * P; dxi++)
      for (int k = 0; k <= P; k++)
        for (int j = 0; j < N; j++) begin
          logic [(N+1)*8-1:0] col;
          for (int i = 0; i <= N; i++) begin
            int row = 2 * k + i;
            col[i*8 +: 8] = 8'((row < H) ? area[row][dxi + j] : trap[dxi + j]);
          end
          if (gaps && ((j + k) % 2 == 0)) tick(junk, '1, 1'b0, '1);  // R11
          tick(junk, {N{8'h5a}}, 1'b1, col);
        end
    tick(1'b0, '0, 1'b0, '0);
  endtask

  task automatic copy_ref(input int dxi, input int dyi);
    for (int r = 0; r < N; r++)
      for (int c = 0; c < N; c++) refb[r][c] = area[dyi + r][dxi + c];
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL R9 watchdog: actual %0d expected %0d", 1, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    for (int c = 0; c < H; c++) trap[c] = 0;
    repeat (3) @(negedge clk);
    // R1 reset state
    check(busy == 1'b0, "R1", "busy_o", int'(busy), 0);
    check(done == 1'b0, "R1", "done_o", int'(done), 0);
    check(int'(sad) == (1 << SAD_W) - 1, "R1", "sad_o", int'(sad), (1 << SAD_W) - 1);
    check(mv_x == 0 && mv_y == 0, "R1", "mv", int'(mv_x), 0);
    rst_n = 1'b1;

    // R4: search beats while idle change nothing
    res_req = "R4";
    repeat (5) tick(1'b0, '0, 1'b1, '1);

    // MB1: exact match for a lower-unit candidate, with gaps and junk ref strobes (R3, R5, R11)
    for (int r = 0; r < H; r++) for (int c = 0; c < H; c++) area[r][c] = int'($urandom_range(255, 0));
    copy_ref(3, 3);
    load_ref();
    res_req = "R3/R5/R11";
    run_search(1'b1, 1'b1);
    check(e_x == 1 && e_y == 1, "R5", "model vector", e_x, 1);

    // MB2: upper-unit winner in the last pass (R5, R7)
    for (int r = 0; r < H; r++) for (int c = 0; c < H; c++) area[r][c] = int'($urandom_range(255, 0));
    copy_ref(0, 4);
    load_ref();
    res_req = "R5/R7";
    run_search(1'b0, 1'b0);

    // MB3: flat image, every position ties at zero (R8)
    for (int r = 0; r < H; r++) for (int c = 0; c < H; c++) area[r][c] = 10;
    for (int r = 0; r < N; r++) for (int c = 0; c < N; c++) refb[r][c] = 10;
    load_ref();
    res_req = "R8";
    run_search(1'b0, 1'b0);
    check(int'(mv_x) == -P && int'(mv_y) == -P, "R8", "tie winner", int'(mv_x), -P);

    // MB4: only large SADs after a zero-SAD search (R10)
    for (int r = 0; r < H; r++) for (int c = 0; c < H; c++) area[r][c] = int'($urandom_range(99, 0));
    for (int r = 0; r < N; r++) for (int c = 0; c < N; c++) refb[r][c] = 200;
    load_ref();
    res_req = "R10";
    run_search(1'b1, 1'b0);
    check(int'(sad) > 0, "R10", "sad_o nonzero", int'(sad), e_sad);

    // MB5: trap row in the last pass would give a perfect lower match (R6)
    for (int r = 0; r < H; r++) for (int c = 0; c < H; c++) area[r][c] = int'($urandom_range(99, 0));
    for (int r = 0; r < N - 1; r++) for (int c = 0; c < N; c++) refb[r][c] = area[2 * P + 1 + r][c];
    for (int c = 0; c < N; c++) begin refb[N-1][c] = 255; trap[c] = 255; end
    load_ref();
    res_req = "R6";
    run_search(1'b0, 1'b0);
    check(int'(mv_y) <= P, "R6", "mv_y_o", int'(mv_y), e_y);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule